// File: doc/BRIEF.md
# One-Time-Programmable Word Memory

This block models a small on-chip one-time-programmable memory. The array is organised as 32-bit words, and a parameter sets how many words it holds. Software-visible reads arrive on a byte-addressed read port. The port returns one, two or four bytes from any byte address, packed little-endian into a 32-bit result. The word at index `w` starts at byte offset `4*w`.

Words are written only through a separate programming port. A request names a word index and a 32-bit mask in which a 0 bit selects a bit to burn. Burning is one-way, and its direction depends on the parity of the word index. Even words leave reset as all zeros, and burning drives the selected bits to 1. Odd words leave reset as all ones, and burning drives the selected bits to 0.

Before a request is applied, it is compared with the stored word. It is refused when the stored word already equals the inverted mask. Selected bits that were already burnt are reported on a conflict vector, but conflicts alone do not refuse the request. Each request completes one cycle after it is issued. Requests outside the array are flagged as errors and change nothing.

Top module: `otp_word_mem`

## Requirements
- R1: A synchronous reset loads every even-indexed word with 0x00000000 and every odd-indexed word with 0xFFFFFFFF. It also drives all completion, error, conflict and read-data outputs to 0.
- R2: For an even word index, each bit whose mask bit is 0 becomes 1, and bits whose mask bit is 1 keep their value. Parity is bit 0 of the word index.
- R3: For an odd word index, each bit whose mask bit is 0 becomes 0, and bits whose mask bit is 1 keep their value.
- R4: When the stored word equals the bitwise inverse of the mask, `progReject` is 1 and the word keeps its value. This also covers an all-ones mask on an even blank word and an all-zeros mask on an odd blank word.
- R5: `progConflict` marks the targeted bits that are already in the burnt state: 1s for an even word, 0s for an odd word. A request that has conflicts but does not meet the R4 condition is still applied, with `progReject` = 0.
- R6: `progDone` is 1 exactly in the cycle after a cycle in which `progValid` was 1. `progReject`, `progErr` and `progConflict` are valid in that same cycle.
- R7: `rdDone` is 1 in the cycle after `rdEn`. `rdData` then holds byte `rdAddr+k` in bits `[8k+7:8k]` for each byte of the access, and zeros above the access. The `rdSize` encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Any byte alignment is accepted.
- R8: A read that would touch any byte at or beyond `4*NUM_WORDS`, or that uses `rdSize` = 3, returns `rdData` = 0 with `rdErr` = 1.
- R9: A program request with an index of `NUM_WORDS` or more sets `progErr` = 1, with `progReject` = 0 and `progConflict` = 0. It leaves every word unchanged, including the word its low index bits would alias.
- R10: A read issued in the same cycle as a program request to the same word returns the word as it was before that request.
- R11: Once burnt, a bit never returns to its blank value. Burning the same bits a second time leaves the word unchanged and flags exactly those bits as conflicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| progValid | input | 1 | Single-cycle program request |
| progIdx | input | ADDR_W-2 | Word index of the program request |
| progMask | input | 32 | Program mask, 0 selects a bit to burn |
| progDone | output | 1 | Program request completed |
| progReject | output | 1 | Request refused, word unchanged |
| progErr | output | 1 | Index beyond the array |
| progConflict | output | 32 | Targeted bits already burnt |
| rdEn | input | 1 | Single-cycle read request |
| rdAddr | input | ADDR_W | Byte address of the read |
| rdSize | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| rdDone | output | 1 | Read completed |
| rdErr | output | 1 | Read out of range or bad size |
| rdData | output | 32 | Little-endian read result |

## Verification
The bench builds the block with `NUM_WORDS` = 12 and `ADDR_W` = 8, which gives a 48-byte array inside a 256-byte address space. Because the word count is not a power of two, the last legal byte (47) and the first illegal one (48) sit away from any natural address boundary. Straddling reads at that edge are therefore distinguishable from plain address overflow. Index 16 aliases word 0 in the low index bits, so an out-of-range program request can be shown not to disturb the word it would otherwise hit.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef logic [31:0] otpWord_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic progCommit;  // apply the computed word to storage
    logic rdLoad;      // capture assembled read bytes
    logic rdClear;     // force read data to zero
  } otpStrobes_t;

  typedef enum logic [1:0] {
    RD_ONE  = 2'd0,
    RD_TWO  = 2'd1,
    RD_FOUR = 2'd2,
    RD_BAD  = 2'd3
  } rdSize_e;

  function automatic otpWord_t blankWord(input logic isOdd);
    return isOdd ? '1 : '0;
  endfunction

  function automatic logic [2:0] sizeBytes(input logic [1:0] code);
    case (rdSize_e'(code))
      RD_ONE:  return 3'd1;
      RD_TWO:  return 3'd2;
      RD_FOUR: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/otp_datapath.sv
module otp_datapath
  import otp_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int ADDR_W    = 8,
  parameter int WSEL_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  otpStrobes_t       strb,
  input  logic [WSEL_W-1:0] progWord,
  input  otpWord_t          progMask,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  output otpWord_t          conflictBits,
  output logic              progBlocked,
  output otpWord_t          rdData
);

  localparam int LANES = 4;

  otpWord_t mem [NUM_WORDS];

  otpWord_t curWord;
  otpWord_t targets;
  otpWord_t nextWord;
  logic     wordOdd;

  assign wordOdd  = progWord[0];
  assign curWord  = mem[progWord];
  assign targets  = ~progMask;

  always_comb begin
    if (wordOdd) begin
      conflictBits = ~curWord & targets;
      nextWord     = curWord & progMask;
    end else begin
      conflictBits = curWord & targets;
      nextWord     = curWord | targets;
    end
  end

  assign progBlocked = (curWord == targets);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        mem[i] <= blankWord(1'(i % 2));
      end
    end else if (strb.progCommit) begin
      mem[progWord] <= nextWord;
    end
  end

  // Byte lanes of the read path
  logic [2:0] rdBytes;
  otpWord_t   rdAssembled;

  assign rdBytes = sizeBytes(rdSize);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W:0]   laneAddr;
    logic [WSEL_W-1:0] laneWord;
    logic [7:0]        laneByte;
    logic              laneKeep;

    assign laneAddr = {1'b0, rdAddr} + (ADDR_W+1)'(k);
    assign laneWord = WSEL_W'(laneAddr >> 2);
    assign laneByte = mem[laneWord][{laneAddr[1:0], 3'b000} +: 8];
    assign laneKeep = (3'(k) < rdBytes);
    assign rdAssembled[k*8 +: 8] = laneKeep ? laneByte : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.rdLoad) begin
      rdData <= rdAssembled;
    end else if (strb.rdClear) begin
      rdData <= '0;
    end
  end

  AST_EVEN_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    (strb.progCommit && !wordOdd) |=>
      ((mem[$past(progWord)] & $past(curWord)) == $past(curWord))); // R2

  AST_ODD_ONE_WAY: assert property (@(posedge clk) disable iff (rst)
    (strb.progCommit && wordOdd) |=>
      ((mem[$past(progWord)] | $past(curWord)) == $past(curWord))); // R3

  AST_HOLD_UNCOMMITTED: assert property (@(posedge clk) disable iff (rst)
    !strb.progCommit |=> (mem[$past(progWord)] == $past(curWord))); // R4

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(strb.rdLoad && strb.rdClear)); // R8

endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              progValid,
  input  logic [IDX_W-1:0]  progIdx,
  input  logic              progBlocked,
  input  otpWord_t          conflictBits,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  output otpStrobes_t       strb,
  output logic              progDone,
  output logic              progReject,
  output logic              progErr,
  output otpWord_t          progConflict,
  output logic              rdDone,
  output logic              rdErr
);

  localparam int BYTES = NUM_WORDS * 4;

  logic            progInRange;
  logic [ADDR_W:0] rdEnd;
  logic            rdOk;

  assign progInRange = ({1'b0, progIdx} < (IDX_W+1)'(NUM_WORDS));
  assign rdEnd       = {1'b0, rdAddr} + (ADDR_W+1)'(sizeBytes(rdSize));
  assign rdOk        = (rdSize_e'(rdSize) != RD_BAD) &&
                       (rdEnd <= (ADDR_W+1)'(BYTES));

  always_comb begin
    strb.progCommit = progValid && progInRange && !progBlocked;
    strb.rdLoad     = rdEn && rdOk;
    strb.rdClear    = rdEn && !rdOk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      progDone     <= 1'b0;
      progReject   <= 1'b0;
      progErr      <= 1'b0;
      progConflict <= '0;
      rdDone       <= 1'b0;
      rdErr        <= 1'b0;
    end else begin
      progDone     <= progValid;
      progReject   <= progValid && progInRange && progBlocked;
      progErr      <= progValid && !progInRange;
      progConflict <= (progValid && progInRange) ? conflictBits : '0;
      rdDone       <= rdEn;
      rdErr        <= rdEn && !rdOk;
    end
  end

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    progValid |=> progDone); // R6

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !progValid |=> !progDone); // R6

  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (rst)
    progErr |-> (!progReject && progConflict == '0)); // R9

  AST_RD_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    rdEn |=> rdDone); // R7

  AST_FLAGS_NEED_DONE: assert property (@(posedge clk) disable iff (rst)
    !progDone |-> (!progReject && !progErr)); // R6

endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
  import otp_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              progValid,
  input  logic [ADDR_W-3:0] progIdx,
  input  logic [31:0]       progMask,
  output logic              progDone,
  output logic              progReject,
  output logic              progErr,
  output logic [31:0]       progConflict,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  output logic              rdDone,
  output logic              rdErr,
  output logic [31:0]       rdData
);

  localparam int IDX_W  = ADDR_W - 2;
  localparam int WSEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  if (NUM_WORDS < 1 || NUM_WORDS * 4 > (2 ** ADDR_W)) begin : g_badSize
    $error("otp_word_mem: NUM_WORDS must be nonzero and fit in ADDR_W");
  end

  otpStrobes_t       strb;
  otpWord_t          conflictBits;
  logic              progBlocked;
  logic [WSEL_W-1:0] progWord;

  assign progWord = WSEL_W'(progIdx);

  otp_ctrl #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
  ) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .progValid    (progValid),
    .progIdx      (progIdx),
    .progBlocked  (progBlocked),
    .conflictBits (conflictBits),
    .rdEn         (rdEn),
    .rdAddr       (rdAddr),
    .rdSize       (rdSize),
    .strb         (strb),
    .progDone     (progDone),
    .progReject   (progReject),
    .progErr      (progErr),
    .progConflict (progConflict),
    .rdDone       (rdDone),
    .rdErr        (rdErr)
  );

  otp_datapath #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W),
    .WSEL_W    (WSEL_W)
  ) i_datapath (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .progWord     (progWord),
    .progMask     (progMask),
    .rdAddr       (rdAddr),
    .rdSize       (rdSize),
    .conflictBits (conflictBits),
    .progBlocked  (progBlocked),
    .rdData       (rdData)
  );

  AST_RD_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdErr |-> (rdData == '0)); // R8

  AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rdDone |-> !rdErr); // R7

endmodule

// File: tb/test_otp_word_mem.sv
module test_otp_word_mem;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 12;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        progValid = 1'b0;
  logic [5:0]  progIdx = '0;
  logic [31:0] progMask = '1;
  logic        progDone, progReject, progErr;
  logic [31:0] progConflict;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [1:0]  rdSize = '0;
  logic        rdDone, rdErr;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_word_mem #(.NUM_WORDS(NW), .ADDR_W(AW)) i_otp_word_mem (
    .clk(clk), .rst(rst),
    .progValid(progValid), .progIdx(progIdx), .progMask(progMask),
    .progDone(progDone), .progReject(progReject), .progErr(progErr),
    .progConflict(progConflict),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdSize(rdSize),
    .rdDone(rdDone), .rdErr(rdErr), .rdData(rdData)
  );

  // isRead, addr/index, mask/size, expected data/conflict, reject, err, req
  typedef struct packed {
    logic        isRead;
    logic [7:0]  addr;
    logic [31:0] arg;
    logic [31:0] expVal;
    logic        expFlag;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,  32'hFFFFFF0F, 32'h00000000, 1'b0, 1'b0, 4'd2},  // R2 burn 0xF0
    '{1'b1, 8'd0,  32'd2,        32'h000000F0, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'd0,  32'hFFFFFF0F, 32'h000000F0, 1'b1, 1'b0, 4'd11}, // R11 repeat
    '{1'b1, 8'd0,  32'd2,        32'h000000F0, 1'b0, 1'b0, 4'd11},
    '{1'b0, 8'd0,  32'hFFFF0F3F, 32'h000000C0, 1'b0, 1'b0, 4'd5},  // R5 partial
    '{1'b1, 8'd0,  32'd2,        32'h0000F0F0, 1'b0, 1'b0, 4'd5},
    '{1'b0, 8'd1,  32'h0000FFFF, 32'h00000000, 1'b0, 1'b0, 4'd3},  // R3 odd
    '{1'b1, 8'd4,  32'd2,        32'h0000FFFF, 1'b0, 1'b0, 4'd3},
    '{1'b0, 8'd1,  32'h00FF0FFF, 32'hFF000000, 1'b0, 1'b0, 4'd5},  // R5 odd
    '{1'b1, 8'd4,  32'd2,        32'h00000FFF, 1'b0, 1'b0, 4'd3},
    '{1'b1, 8'd2,  32'd2,        32'h0FFF0000, 1'b0, 1'b0, 4'd7},  // R7 straddle
    '{1'b1, 8'd1,  32'd0,        32'h000000F0, 1'b0, 1'b0, 4'd7},
    '{1'b1, 8'd3,  32'd1,        32'h0000FF00, 1'b0, 1'b0, 4'd7},
    '{1'b1, 8'd5,  32'd2,        32'h0000000F, 1'b0, 1'b0, 4'd7},
    '{1'b1, 8'd47, 32'd0,        32'h000000FF, 1'b0, 1'b0, 4'd8},  // R8 last byte
    '{1'b1, 8'd46, 32'd1,        32'h0000FFFF, 1'b0, 1'b0, 4'd8},
    '{1'b1, 8'd47, 32'd1,        32'h00000000, 1'b0, 1'b1, 4'd8},
    '{1'b1, 8'd45, 32'd2,        32'h00000000, 1'b0, 1'b1, 4'd8},
    '{1'b1, 8'd0,  32'd3,        32'h00000000, 1'b0, 1'b1, 4'd8},
    '{1'b0, 8'd12, 32'h00000000, 32'h00000000, 1'b0, 1'b1, 4'd9},  // R9
    '{1'b0, 8'd16, 32'h00000000, 32'h00000000, 1'b0, 1'b1, 4'd9},
    '{1'b1, 8'd0,  32'd2,        32'h0000F0F0, 1'b0, 1'b0, 4'd9},
    '{1'b0, 8'd11, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 4'd4},  // R4 odd blank
    '{1'b1, 8'd44, 32'd2,        32'hFFFFFFFF, 1'b0, 1'b0, 4'd4},
    '{1'b0, 8'd2,  32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0, 4'd4},
    '{1'b0, 8'd3,  32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0, 4'd4},
    '{1'b1, 8'd12, 32'd2,        32'hFFFFFFFF, 1'b0, 1'b0, 4'd4},
    '{1'b0, 8'd10, 32'h7FFFFFFE, 32'h00000000, 1'b0, 1'b0, 4'd2},
    '{1'b1, 8'd40, 32'd2,        32'h80000001, 1'b0, 1'b0, 4'd2}
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doProg(input logic [5:0] idx, input logic [31:0] mask);
    @(negedge clk);
    progValid = 1'b1; progIdx = idx; progMask = mask;
    @(posedge clk); #1;
    progValid = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] addr, input logic [1:0] size);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = addr; rdSize = size;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state of the outputs
    check(1, "progDone after reset", 32'(progDone), 32'd0);
    check(1, "rdData after reset", rdData, 32'h0);
    doRead(8'd0, 2'd2);
    check(1, "blank even word", rdData, 32'h00000000);
    doRead(8'd4, 2'd2);
    check(1, "blank odd word", rdData, 32'hFFFFFFFF);
    check(7, "rdDone", 32'(rdDone), 32'd1);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].isRead) begin
        doRead(VECS[v].addr, VECS[v].arg[1:0]);
        check(int'(VECS[v].req), $sformatf("vec %0d rdData", v), rdData, VECS[v].expVal);
        check(int'(VECS[v].req), $sformatf("vec %0d rdErr", v), 32'(rdErr), 32'(VECS[v].expErr));
      end else begin
        doProg(VECS[v].addr[5:0], VECS[v].arg);
        check(6, $sformatf("vec %0d progDone", v), 32'(progDone), 32'd1);
        check(int'(VECS[v].req), $sformatf("vec %0d conflict", v), progConflict, VECS[v].expVal);
        check(int'(VECS[v].req), $sformatf("vec %0d reject", v), 32'(progReject), 32'(VECS[v].expFlag));
        check(int'(VECS[v].req), $sformatf("vec %0d err", v), 32'(progErr), 32'(VECS[v].expErr));
      end
    end

    // R6 done pulses once only
    @(posedge clk); #1;
    check(6, "progDone idle", 32'(progDone), 32'd0);

    // R10 read and program in the same cycle
    @(negedge clk);
    progValid = 1'b1; progIdx = 6'd4; progMask = 32'hFFFFFFFE;
    rdEn = 1'b1; rdAddr = 8'd16; rdSize = 2'd2;
    @(posedge clk); #1;
    progValid = 1'b0; rdEn = 1'b0;
    check(10, "read sees old word", rdData, 32'h00000000);
    doRead(8'd16, 2'd2);
    check(10, "read after burn", rdData, 32'h00000001);

    // R1 reset restores the blank pattern
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk) rst = 1'b0;
    doRead(8'd0, 2'd2);
    check(1, "word 0 blank again", rdData, 32'h00000000);
    doRead(8'd4, 2'd2);
    check(1, "word 1 blank again", rdData, 32'hFFFFFFFF);

    summary();
    $finish;
  end

endmodule